// File: doc/BRIEF.md
# Variable-Size Confidence Counter

This block is the digital loop filter of a bang-bang clock-recovery loop. On every clock a half-rate phase detector reports two bit-boundary decisions. Each decision can be early, late or neither. The block turns the pair into one signed net vote and adds that vote to a small signed accumulator. When the running total climbs to the active size N, the block emits a one-cycle lead pulse. When the total falls to one count beyond the negative of N, it emits a one-cycle lag pulse. After either pulse the total restarts from zero. The downstream phase control uses these pulses to step the recovered clock.

The size N sets the equivalent loop bandwidth. A lock-state code from an external lock detector selects it: a wide loop (N = 2) while acquiring, a middle setting (N = 8), and a narrow loop (N = 32) once locked. The sizes are held in a three-state machine. State SZ_COARSE gives N = 2, SZ_MEDIUM gives N = 8 and SZ_FINE gives N = 32. Any state moves to any other state in the cycle after the lock code asks for it. Each such move is a "resize" transition, and it clears the accumulator. A "hold" transition keeps the present state while the code still decodes to it.

Top module: `vcc_conf_counter`

## Requirements
- R1: After reset both pulse outputs are low, the accumulator is zero and the size state is SZ_COARSE (N = 2).
- R2: The vote is the number of asserted lead inputs minus the number of asserted lag inputs. Two leads give +2 (3'b010), two lags give -2 (3'b110), one lead alone gives +1, one lag alone gives -1, and no inputs gives 0. A lead and a lag in the same cycle cancel.
- R3: In a cycle with no resize and no pulse, the accumulator takes the value of its old content plus the vote. It always stays strictly between -(N+1) and N.
- R4: Lock code 2'b00 selects N = 2 (SZ_COARSE), 2'b01 selects N = 8 (SZ_MEDIUM), and 2'b10 or 2'b11 select N = 32 (SZ_FINE). Changing between 2'b10 and 2'b11 is a hold transition.
- R5: When the old total plus the vote is N or more, lead_ov is high for exactly the next cycle.
- R6: When the old total plus the vote is -(N+1) or less, lag_ov is high for exactly the next cycle.
- R7: The vote of a cycle that produces a pulse is used up by that pulse. The accumulator restarts at zero and carries no remainder.
- R8: In a resize cycle the accumulator is cleared, the vote of that cycle is discarded and no pulse is produced.
- R9: lead_ov and lag_ov are never high together, and lag_ov is never high in the cycle right after lead_ov.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_a | input | 1 | First boundary: data early |
| lag_a | input | 1 | First boundary: data late |
| lead_b | input | 1 | Second boundary: data early |
| lag_b | input | 1 | Second boundary: data late |
| lock_code | input | 2 | Size select from the lock detector |
| lead_ov | output | 1 | One-cycle lead overflow pulse |
| lag_ov | output | 1 | One-cycle lag overflow pulse |

## Verification
The bench builds the block with its default sizes 2, 8 and 32, which gives a 6-bit accumulator. At these sizes every mode fires within about seventeen votes. In the widest mode the accumulator runs right up to its +31 and -32 limits, and the asymmetric lag threshold of -33 needs the 7-bit intermediate sum. Directed sequences probe residue carry-over, resize clearing and the 2'b10/2'b11 hold transition. A long random run with occasional code changes follows and is compared against a behavioural model every cycle.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
    typedef enum logic [1:0] {
        SZ_COARSE = 2'd0,
        SZ_MEDIUM = 2'd1,
        SZ_FINE   = 2'd2
    } size_state_e;

    localparam int VOTE_W = 3;
endpackage

// File: rtl/vcc_vote_enc.sv
module vcc_vote_enc
    import vcc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lead_a,
    input  logic                     lag_a,
    input  logic                     lead_b,
    input  logic                     lag_b,
    output logic signed [VOTE_W-1:0] vote
);
    logic [VOTE_W-1:0] ups;
    logic [VOTE_W-1:0] dns;

    always_comb begin
        ups  = VOTE_W'(lead_a) + VOTE_W'(lead_b);
        dns  = VOTE_W'(lag_a) + VOTE_W'(lag_b);
        vote = $signed(ups - dns);
    end

    AST_VOTE_PLUS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (vote == 3'sd2) |-> (lead_a && lead_b && !lag_a && !lag_b)); // R2
    AST_VOTE_MINUS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (vote == -3'sd2) |-> (lag_a && lag_b && !lead_a && !lead_b)); // R2
endmodule

// File: rtl/vcc_size_fsm.sv
module vcc_size_fsm
    import vcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  lock_code,
    output size_state_e state_o,
    output logic        clear_o
);
    size_state_e state_q;
    size_state_e state_d;

    always_comb begin
        unique case (lock_code)
            2'b00:   state_d = SZ_COARSE;
            2'b01:   state_d = SZ_MEDIUM;
            2'b10:   state_d = SZ_FINE;
            2'b11:   state_d = SZ_FINE;
            default: state_d = SZ_FINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SZ_COARSE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o = state_q;
        clear_o = (state_d != state_q);
    end

    AST_RESIZE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (!clear_o || !$stable(lock_code))); // R8
    AST_FINE_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SZ_FINE && lock_code[1]) |-> !clear_o); // R4
endmodule

// File: rtl/vcc_acc_core.sv
module vcc_acc_core
    import vcc_pkg::*;
#(
    parameter int SIZE_LO  = 2,
    parameter int SIZE_MID = 8,
    parameter int SIZE_HI  = 32,
    parameter int ACC_W    = $clog2(SIZE_HI) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [VOTE_W-1:0] vote,
    input  size_state_e              state,
    input  logic                     clear,
    output logic                     lead_o,
    output logic                     lag_o
);
    localparam int SUM_W = ACC_W + 1;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] thr;
    logic signed [SUM_W-1:0] lag_lim;
    logic                    hit_lead;
    logic                    hit_lag;
    logic                    lead_q;
    logic                    lag_q;

    always_comb begin
        unique case (state)
            SZ_COARSE: thr = SUM_W'(SIZE_LO);
            SZ_MEDIUM: thr = SUM_W'(SIZE_MID);
            SZ_FINE:   thr = SUM_W'(SIZE_HI);
            default:   thr = SUM_W'(SIZE_HI);
        endcase
        lag_lim  = -thr - SUM_W'(1);
        sum      = $signed({acc_q[ACC_W-1], acc_q})
                 + $signed({{(SUM_W-VOTE_W){vote[VOTE_W-1]}}, vote});
        hit_lead = (sum >= thr);
        hit_lag  = (sum <= lag_lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lead_q <= 1'b0;
            lag_q  <= 1'b0;
        end else if (clear) begin
            acc_q  <= '0;
            lead_q <= 1'b0;
            lag_q  <= 1'b0;
        end else if (hit_lead) begin
            acc_q  <= '0;
            lead_q <= 1'b1;
            lag_q  <= 1'b0;
        end else if (hit_lag) begin
            acc_q  <= '0;
            lead_q <= 1'b0;
            lag_q  <= 1'b1;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            lead_q <= 1'b0;
            lag_q  <= 1'b0;
        end
    end

    always_comb begin
        lead_o = lead_q;
        lag_o  = lag_q;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0 && !lead_q && !lag_q)); // R8
    AST_LEAD_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        lead_q |-> ($past(acc_q) >= $past(thr) - 2)); // R5
    AST_LAG_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        lag_q |-> ($past(acc_q) <= $past(lag_lim) + 2)); // R6
    AST_ACC_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < thr) && (acc_q > lag_lim)); // R3
    AST_NO_LAG_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        lead_q |=> !lag_q); // R9
endmodule

// File: rtl/vcc_conf_counter.sv
module vcc_conf_counter
    import vcc_pkg::*;
#(
    parameter int SIZE_LO  = 2,
    parameter int SIZE_MID = 8,
    parameter int SIZE_HI  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lead_a,
    input  logic       lag_a,
    input  logic       lead_b,
    input  logic       lag_b,
    input  logic [1:0] lock_code,
    output logic       lead_ov,
    output logic       lag_ov
);
    localparam int ACC_W = $clog2(SIZE_HI) + 1;

    logic signed [VOTE_W-1:0] vote;
    size_state_e              state;
    logic                     clear;

    vcc_vote_enc u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .lead_a (lead_a),
        .lag_a  (lag_a),
        .lead_b (lead_b),
        .lag_b  (lag_b),
        .vote   (vote)
    );

    vcc_size_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_code (lock_code),
        .state_o   (state),
        .clear_o   (clear)
    );

    vcc_acc_core #(
        .SIZE_LO  (SIZE_LO),
        .SIZE_MID (SIZE_MID),
        .SIZE_HI  (SIZE_HI),
        .ACC_W    (ACC_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .vote   (vote),
        .state  (state),
        .clear  (clear),
        .lead_o (lead_ov),
        .lag_o  (lag_ov)
    );

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_ov && lag_ov)); // R9
endmodule

// File: tb/vcc_conf_counter_test.sv
`timescale 1ns/1ps
module vcc_conf_counter_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lead_a, lag_a, lead_b, lag_b;
    logic [1:0] lock_code;
    logic       lead_ov, lag_ov;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int m_acc;
    int m_n;
    bit m_lead;
    bit m_lag;

    always #2.5 clk = ~clk;

    vcc_conf_counter uut (
        .clk(clk), .rst_n(rst_n),
        .lead_a(lead_a), .lag_a(lag_a), .lead_b(lead_b), .lag_b(lag_b),
        .lock_code(lock_code), .lead_ov(lead_ov), .lag_ov(lag_ov)
    );

    function automatic int size_of(input logic [1:0] code);
        if (code == 2'b00) return 2;
        if (code == 2'b01) return 8;
        return 32;
    endfunction

    task automatic check(input string req, input bit exp_lead, input bit exp_lag);
        checks++;
        if (lead_ov !== exp_lead || lag_ov !== exp_lag) begin
            failures++;
            $display("FAIL %s: lead/lag actual=%b%b expected=%b%b", req,
                     lead_ov, lag_ov, exp_lead, exp_lag);
        end
    endtask

    task automatic model_step();
        int n_new;
        int v;
        int s;
        n_new = size_of(lock_code);
        v = int'(lead_a) + int'(lead_b) - int'(lag_a) - int'(lag_b);
        m_lead = 0;
        m_lag  = 0;
        if (n_new != m_n) begin
            m_n = n_new;
            m_acc = 0;
        end else begin
            s = m_acc + v;
            if (s >= m_n) begin
                m_lead = 1;
                m_acc = 0;
            end else if (s <= -(m_n + 1)) begin
                m_lag = 1;
                m_acc = 0;
            end else begin
                m_acc = s;
            end
        end
    endtask

    task automatic step(input bit l1, input bit g1, input bit l2, input bit g2,
                        input logic [1:0] code, input string req);
        lead_a = l1; lag_a = g1; lead_b = l2; lag_b = g2; lock_code = code;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, m_lead, m_lag);
        checks++;
        if (lead_ov && lag_ov) begin
            failures++;
            $display("FAIL R9: both pulses high actual=11 expected=not 11");
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; lead_a = 0; lag_a = 0; lead_b = 0; lag_b = 0; lock_code = 2'b00;
        m_acc = 0; m_n = 2; m_lead = 0; m_lag = 0;
        repeat (3) @(negedge clk);
        check("R1", 0, 0);
        rst_n = 1;

        // R1: starts at zero in size 2: +1 then +1 fires lead
        step(1,0,0,0, 2'b00, "R1");
        step(0,0,1,0, 2'b00, "R1");
        // R2 vote encodings
        step(1,0,1,0, 2'b00, "R2");
        step(0,1,0,1, 2'b00, "R2");
        step(0,0,0,1, 2'b00, "R6");
        step(1,1,0,0, 2'b00, "R2");
        step(0,0,1,1, 2'b00, "R2");
        step(0,0,0,0, 2'b00, "R3");
        // R7: acc 1 then +2 -> lead, no carry
        step(1,0,0,0, 2'b00, "R3");
        step(1,0,1,0, 2'b00, "R7");
        step(0,1,0,1, 2'b00, "R7");
        step(0,1,0,0, 2'b00, "R7");
        // R8: leave residue, then resize to 8 with a discarded vote
        step(1,0,0,0, 2'b00, "R3");
        step(1,0,1,0, 2'b01, "R8");
        for (int i = 0; i < 4; i++) step(1,0,1,0, 2'b01, "R4");
        for (int i = 0; i < 4; i++) step(0,1,0,1, 2'b01, "R6");
        step(0,1,0,0, 2'b01, "R6");
        // size 32
        step(0,0,0,0, 2'b10, "R8");
        for (int i = 0; i < 15; i++) step(1,0,1,0, 2'b10, "R3");
        step(0,0,0,0, 2'b11, "R4");
        step(1,0,0,0, 2'b11, "R5");
        step(1,0,0,0, 2'b10, "R5");
        for (int i = 0; i < 16; i++) step(0,1,0,1, 2'b11, "R3");
        step(0,0,0,1, 2'b10, "R6");
        // back to size 2 mid-way
        for (int i = 0; i < 5; i++) step(1,0,1,0, 2'b10, "R3");
        step(0,0,0,0, 2'b00, "R8");
        step(1,0,1,0, 2'b00, "R5");
        // random run
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] c;
            c = lock_code;
            if ($urandom_range(0, 99) < 3) c = 2'($urandom_range(0, 3));
            step(1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                 1'($urandom_range(0,1)), 1'($urandom_range(0,1)), c, "R3");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule